// File: doc/BRIEF.md
# Single-Edge Multi-Channel PWM Timer

This block is a 16-bit up-counting timer with four match channels, each able to drive a single-edge PWM pin. The highest channel defines the PWM period: when the counter reaches that channel's match value, the next counting tick returns the counter to zero. That tick starts a new PWM cycle. Each channel output is cleared at the start of every cycle and set when the counter reaches the channel's own match value, so the match value sets the LOW time and the remaining part of the period is the HIGH time.

Software drives a small register port. It writes the four match values, a PWM-enable mask and a mask of static pin levels. Any channel whose enable bit is clear drives its pin from the static level bit instead of from PWM. The counter advances only on cycles where the prescale tick input is high. All match values, including the period, are copied into shadow registers at each cycle boundary, so the duty of a running cycle is not changed by later writes.

Each channel output comes from a three-state machine with these states:
- `CH_LOW`: waiting for the match.
- `CH_HIGH`: set by a match during the cycle.
- `CH_HELD`: set at cycle start because the match value is zero.

The state machine has these transitions:
- **wrap**: on any tick that restarts the cycle, every state goes to `CH_HELD` if the newly loaded match value is zero, and to `CH_LOW` otherwise.
- **hit**: on a counting tick, `CH_LOW` goes to `CH_HIGH` when the incremented count equals the shadow match value.
- **hold**: `CH_HIGH` and `CH_HELD` stay where they are until the next wrap.

Top module: `pwm_timer`

## Requirements
- R1: After reset, every pin is LOW and every register reads back 0.
- R2: The counter changes only on cycles with `tick_i` high. It steps by one up to the shadow period, which is the value at address 3, and the next tick returns it to 0. The pin waveforms therefore repeat every period+1 ticks.
- R3: On the tick that returns the counter to 0, every PWM-enabled pin whose newly loaded match value is nonzero becomes LOW.
- R4: A PWM-enabled pin becomes HIGH on the tick that brings the counter to its shadow match value. It stays HIGH until the next cycle start.
- R5: A PWM-enabled pin whose shadow match value exceeds the shadow period stays LOW for the whole cycle.
- R6: A PWM-enabled pin whose match value equals the period gives a HIGH pulse exactly one tick wide, once per period.
- R7: A PWM-enabled pin with match value 0 stays LOW until the counter first returns to 0. It becomes HIGH then and stays HIGH continuously.
- R8: A match value written during a cycle takes effect at the next cycle start. If a pin is already HIGH and its match is raised beyond the period, the pin stays HIGH until the next cycle start and is LOW afterwards.
- R9: Address 4 bits 3:0 form the PWM-enable mask, with bit n controlling channel n. While bit n is 0, pin n equals bit n of the static level register at address 5, from the cycle after the write.
- R10: Addresses 0 to 3 hold the 16-bit match values of channels 0 to 3, and the registers read back what was written. Bits 15:4 at addresses 4 and 5 read 0. Addresses 6 and 7 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Prescale tick; counter advances when high |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational from `reg_addr`) |
| pwm_o | output | 4 | Channel output pins |

## Verification
The assertions take for granted that the counter only sees a period through its shadow copy. They also assume the enable mask can change in any cycle, so each channel property is excused when the channel is in static mode. The stimulus keeps match and period values in a small range, mostly 0 to 18. This makes zero, equal-to-period and beyond-period values frequent and keeps periods short enough that many cycle boundaries are crossed. The stimulus mixes ticks on about seventy percent of cycles with occasional writes to every address, including the unused ones.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

    // Per-channel output state
    typedef enum logic [1:0] {
        CH_LOW  = 2'd0,   // waiting for match in this cycle
        CH_HIGH = 2'd1,   // set by a match during the cycle
        CH_HELD = 2'd2    // set at cycle start by a zero match value
    } ch_state_e;

endpackage

// File: rtl/pwm_regfile.sv
module pwm_regfile #(
    parameter int NCH    = 4,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           we,
    input  logic [ADDR_W-1:0]              addr,
    input  logic [CNT_W-1:0]               wdata,
    output logic [NCH-1:0][CNT_W-1:0]      match_q,
    output logic [NCH-1:0]                 en_q,
    output logic [NCH-1:0]                 lvl_q,
    output logic [CNT_W-1:0]               rdata
);

    localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(NCH);
    localparam logic [ADDR_W-1:0] A_LVL = ADDR_W'(NCH + 1);
    localparam int                PAD_W = CNT_W - NCH;

    for (genvar g = 0; g < NCH; g++) begin : g_match
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                match_q[g] <= '0;
            end else if (we && (addr == ADDR_W'(g))) begin
                match_q[g] <= wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (we && (addr == A_EN)) begin
            en_q <= wdata[NCH-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q <= '0;
        end else if (we && (addr == A_LVL)) begin
            lvl_q <= wdata[NCH-1:0];
        end
    end

    // Read mux: unused addresses and reserved bits return zero
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NCH; i++) begin
            if (addr == ADDR_W'(i)) begin
                rdata = match_q[i];
            end
        end
        if (addr == A_EN) begin
            rdata = {{PAD_W{1'b0}}, en_q};
        end
        if (addr == A_LVL) begin
            rdata = {{PAD_W{1'b0}}, lvl_q};
        end
    end

endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
    parameter int NCH    = 4,
    parameter int CNT_W  = 16,
    parameter int PER_CH = NCH - 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tick_i,
    input  logic [NCH-1:0][CNT_W-1:0]  match_i,
    output logic [CNT_W-1:0]           cnt_o,
    output logic [CNT_W-1:0]           period_o,
    output logic [NCH-1:0][CNT_W-1:0]  sh_o,
    output logic                       wrap_o
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0]          cnt_q;
    logic [NCH-1:0][CNT_W-1:0] sh_q;
    logic                      at_top;

    assign at_top   = (cnt_q == sh_q[PER_CH]);
    assign wrap_o   = tick_i && at_top;
    assign cnt_o    = cnt_q;
    assign period_o = sh_q[PER_CH];
    assign sh_o     = sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (wrap_o) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= cnt_q + CNT_ONE;
        end
    end

    // Shadow copies are refreshed only at the cycle boundary
    for (genvar g = 0; g < NCH; g++) begin : g_shadow
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sh_q[g] <= '0;
            end else if (wrap_o) begin
                sh_q[g] <= match_i[g];
            end
        end
    end

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              wrap_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [CNT_W-1:0]  sh_i,
    input  logic [CNT_W-1:0]  load_i,
    input  logic              en_i,
    input  logic              lvl_i,
    output logic              pin_o
);

    localparam logic [CNT_W:0] WIDE_ONE = (CNT_W + 1)'(1);

    ch_state_e state_q;
    ch_state_e state_d;
    logic      hit;
    logic      zero_next;
    logic      pwm_lvl;

    assign zero_next = (load_i == '0);
    assign hit       = ({1'b0, sh_i} == ({1'b0, cnt_i} + WIDE_ONE));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        if (tick_i) begin
            if (wrap_i) begin
                state_d = zero_next ? CH_HELD : CH_LOW;
            end else begin
                unique case (state_q)
                    CH_LOW:  if (hit) state_d = CH_HIGH;
                    CH_HIGH: state_d = CH_HIGH;
                    CH_HELD: state_d = CH_HELD;
                    default: state_d = CH_LOW;
                endcase
            end
        end
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            CH_LOW:  pwm_lvl = 1'b0;
            CH_HIGH: pwm_lvl = 1'b1;
            CH_HELD: pwm_lvl = 1'b1;
            default: pwm_lvl = 1'b0;
        endcase
        pin_o = en_i ? pwm_lvl : lvl_i;
    end

endmodule

// File: rtl/pwm_timer.sv
module pwm_timer #(
    parameter int NCH    = 4,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = $clog2(NCH + 2),
    parameter int PER_CH = NCH - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [CNT_W-1:0]  reg_wdata,
    output logic [CNT_W-1:0]  reg_rdata,
    output logic [NCH-1:0]    pwm_o
);

    logic [NCH-1:0][CNT_W-1:0] match_q;
    logic [NCH-1:0][CNT_W-1:0] sh;
    logic [NCH-1:0]            en_q;
    logic [NCH-1:0]            lvl_q;
    logic [CNT_W-1:0]          cnt;
    logic [CNT_W-1:0]          period;
    logic                      wrap;

    pwm_regfile #(
        .NCH    (NCH),
        .CNT_W  (CNT_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (reg_we),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .match_q (match_q),
        .en_q    (en_q),
        .lvl_q   (lvl_q),
        .rdata   (reg_rdata)
    );

    pwm_counter #(
        .NCH    (NCH),
        .CNT_W  (CNT_W),
        .PER_CH (PER_CH)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick_i),
        .match_i  (match_q),
        .cnt_o    (cnt),
        .period_o (period),
        .sh_o     (sh),
        .wrap_o   (wrap)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        pwm_channel #(
            .CNT_W (CNT_W)
        ) u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick_i (tick_i),
            .wrap_i (wrap),
            .cnt_i  (cnt),
            .sh_i   (sh[g]),
            .load_i (match_q[g]),
            .en_i   (en_q[g]),
            .lvl_i  (lvl_q[g]),
            .pin_o  (pwm_o[g])
        );
    end

endmodule

// File: rtl/pwm_timer_chk.sv
module pwm_timer_chk #(
    parameter int NCH   = 4,
    parameter int CNT_W = 16
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      tick_i,
    input logic [CNT_W-1:0]          cnt,
    input logic [CNT_W-1:0]          period,
    input logic [NCH-1:0][CNT_W-1:0] sh,
    input logic [NCH-1:0]            en,
    input logic [NCH-1:0]            pwm_o
);

    localparam logic [CNT_W-1:0] C_ONE = CNT_W'(1);

    AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n) cnt <= period); // R2
    AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) !tick_i |=> $stable(cnt)); // R2
    AST_CNT_WRAPS: assert property (@(posedge clk) disable iff (!rst_n) (tick_i && cnt == period) |=> cnt == '0); // R2
    AST_CNT_STEPS: assert property (@(posedge clk) disable iff (!rst_n) (tick_i && cnt != period) |=> cnt == $past(cnt) + C_ONE); // R2

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        AST_CYCLE_START: assert property (@(posedge clk) disable iff (!rst_n) (tick_i && cnt == period) |=> (!en[g] || pwm_o[g] == (sh[g] == '0))); // R3
        AST_BEYOND_LOW: assert property (@(posedge clk) disable iff (!rst_n) (en[g] && sh[g] > period) |-> !pwm_o[g]); // R5
        AST_HIGH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (en[g] && pwm_o[g] && !(tick_i && cnt == period)) |=> (!en[g] || pwm_o[g])); // R4
    end

endmodule

bind pwm_timer pwm_timer_chk #(
    .NCH   (NCH),
    .CNT_W (CNT_W)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (tick_i),
    .cnt    (cnt),
    .period (period),
    .sh     (sh),
    .en     (en_q),
    .pwm_o  (pwm_o)
);

// File: tb/tb_pwm_timer.sv
module tb_pwm_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [3:0]  pwm_o;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    // Reference state built from the requirements
    logic [15:0] m_reg [4];
    logic [15:0] m_sh  [4];
    logic [15:0] m_cnt;
    logic [3:0]  m_en, m_lvl, m_out;
    bit          m_wrapped;
    string       tag_ovr = "";

    always #4 clk = ~clk;   // 125 MHz

    pwm_timer dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pwm_o     (pwm_o)
    );

    function automatic string cat(input int i);
        if (tag_ovr != "")              return tag_ovr;
        if (!m_en[i])                   return "R9";
        if (m_wrapped && m_sh[i] != 0)  return "R3";
        if (m_sh[i] == 0)               return "R7";
        if (m_sh[i] > m_sh[3])          return "R5";
        if (m_sh[i] == m_sh[3])         return "R6";
        return "R4";
    endfunction

    function automatic logic exp_pin(input int i);
        return m_en[i] ? m_out[i] : m_lvl[i];
    endfunction

    task automatic model_edge(input bit t, input bit we, input logic [2:0] a, input logic [15:0] d);
        m_wrapped = 1'b0;
        if (t) begin
            if (m_cnt == m_sh[3]) begin
                m_cnt = 0;
                m_wrapped = 1'b1;
                for (int i = 0; i < 4; i++) begin
                    m_sh[i]  = m_reg[i];
                    m_out[i] = (m_reg[i] == 0);
                end
            end else begin
                m_cnt = m_cnt + 1;
                for (int i = 0; i < 4; i++)
                    if (m_sh[i] == m_cnt) m_out[i] = 1'b1;
            end
        end
        if (we) begin
            if (a < 4)       m_reg[a] = d;
            else if (a == 4) m_en  = d[3:0];
            else if (a == 5) m_lvl = d[3:0];
        end
    endtask

    task automatic check_pins();
        for (int i = 0; i < 4; i++) begin
            checks++;
            if (pwm_o[i] !== exp_pin(i)) begin
                errors++;
                $display("FAIL %s ch%0d pin actual=%0b expected=%0b", cat(i), i, pwm_o[i], exp_pin(i));
            end
        end
    endtask

    task automatic step(input bit t, input bit we, input logic [2:0] a, input logic [15:0] d);
        tick_i = t; reg_we = we; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        model_edge(t, we, a, d);
        @(negedge clk);
        reg_we = 1'b0; tick_i = 1'b0;
        check_pins();
    endtask

    task automatic chk_read(input logic [2:0] a, input logic [15:0] exp, input string tag);
        reg_addr = a;
        #1;
        checks++;
        if (reg_rdata !== exp) begin
            errors++;
            $display("FAIL %s read addr=%0d actual=%h expected=%h", tag, a, reg_rdata, exp);
        end
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 4; i++) begin m_reg[i] = 0; m_sh[i] = 0; end
        m_cnt = 0; m_en = 0; m_lvl = 0; m_out = 0; m_wrapped = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        tag_ovr = "R1";
        check_pins();
        for (int a = 0; a < 8; a++) chk_read(3'(a), 16'h0000, "R1");

        // Directed: period 9, ch0 mid, ch1 zero, ch2 beyond, ch3 equal
        step(0, 1, 3'd3, 16'd9);
        step(0, 1, 3'd0, 16'd3);
        step(0, 1, 3'd1, 16'd0);
        step(0, 1, 3'd2, 16'd12);
        step(0, 1, 3'd4, 16'h000F);
        tag_ovr = "";
        for (int k = 0; k < 25; k++) step(1, 0, 3'd0, 16'd0);

        // R8: raise ch0 beyond period while it is HIGH
        tag_ovr = "R8";
        while (!(m_cnt >= 4 && m_cnt < 8)) step(1, 0, 3'd0, 16'd0);
        step(1, 1, 3'd0, 16'd20);
        for (int k = 0; k < 14; k++) step(1, 0, 3'd0, 16'd0);
        step(1, 1, 3'd0, 16'd5);

        // R2: sparse ticks and a period change
        tag_ovr = "R2";
        step(0, 1, 3'd3, 16'd6);
        for (int k = 0; k < 60; k++) step(k % 3 == 0, 0, 3'd0, 16'd0);

        // R9: static mode on channels 1 and 3
        tag_ovr = "R9";
        step(1, 1, 3'd5, 16'h000A);
        step(1, 1, 3'd4, 16'h0005);
        for (int k = 0; k < 10; k++) step(1, 0, 3'd0, 16'd0);
        step(1, 1, 3'd5, 16'h0005);
        step(1, 0, 3'd0, 16'd0);

        // R10: reserved bits and unused addresses
        tag_ovr = "R10";
        step(0, 1, 3'd6, 16'hFFFF);
        step(0, 1, 3'd7, 16'hA5A5);
        chk_read(3'd6, 16'h0000, "R10");
        chk_read(3'd7, 16'h0000, "R10");
        step(0, 1, 3'd4, 16'hFFF7);
        chk_read(3'd4, 16'h0007, "R10");
        step(0, 1, 3'd5, 16'hFF3C);
        chk_read(3'd5, 16'h000C, "R10");
        chk_read(3'd0, m_reg[0], "R10");
        chk_read(3'd3, m_reg[3], "R10");
        step(0, 1, 3'd2, 16'hBEEF);
        chk_read(3'd2, 16'hBEEF, "R10");
        step(0, 1, 3'd4, 16'h000F);

        // Random mix of ticks and writes
        tag_ovr = "";
        for (int k = 0; k < 4000; k++) begin
            automatic bit          t  = ($urandom % 10) < 7;
            automatic bit          we = ($urandom % 8) == 0;
            automatic logic [2:0]  a  = 3'($urandom % 8);
            automatic logic [15:0] d  = (a < 4) ? 16'($urandom % 19) : 16'($urandom);
            if (a == 4 && ($urandom % 2) == 0) d = 16'h000F;
            step(t, we, a, d);
            if (k % 500 == 0) chk_read(3'd4, {12'h000, m_en}, "R10");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule